// File: doc/BRIEF.md
# Receive Byte Queue with Host Status Word

This block holds bytes produced by a receive datapath until a host microcontroller collects them. The datapath pushes one byte per cycle with a valid strobe. The host removes bytes with a pop strobe. The popped byte appears on `popData` one cycle later.

The host reads a 16-bit status word through a separate read strobe. The word carries the occupancy, two sticky error flags (one for a pop from an empty queue, one for a push into a full queue) and a threshold trigger. The host loads the trigger point through a small threshold write port. The block drives an interrupt request from the error flags and, when enabled, from the trigger.

The status word is a live combinational view of the block state. Strobing `statusRead` acknowledges the two error flags at the next clock edge.

Top module: `rx_byte_fifo`

## Requirements
- R1: After reset the queue is empty, the status word is 0x0000, `popData` is 0x00 and `irq` is low.
- R2: Bytes leave in the order they arrived. The byte selected by a pop strobe is on `popData` from the clock edge that accepts the pop until the next pop.
- R3: Status bits 13..8 give the number of bytes held, from 0 to 32 inclusive. Bits 6..0 always read 0.
- R4: A pop strobe while the queue is empty sets status bit 14 (underflow), loads 0x00 into `popData` and leaves the occupancy unchanged.
- R5: A push while the queue holds 32 bytes and no pop is accepted in the same cycle sets status bit 15 (overflow). The pushed byte is dropped, and the occupancy and the stored bytes are unchanged.
- R6: A cycle with `statusRead` high clears bits 15 and 14 at its closing clock edge. During that cycle the word still shows the uncleared flags. A new error event in the same cycle leaves its flag set.
- R7: Status bit 7 is high exactly when the occupancy is strictly greater than the 5-bit threshold. The threshold is loaded from `thrValue` on a cycle with `thrWrite` high and resets to 0.
- R8: `irq` is high exactly when bit 15 or bit 14 is set, or when bit 7 is set and `trigIrqEn` is high.
- R9: A push and a pop accepted in the same cycle on a non-empty queue leave the occupancy unchanged and keep the byte order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | Datapath writes `pushData` this cycle |
| pushData | input | 8 | Byte from the receive datapath |
| popStrobe | input | 1 | Host removes the oldest byte |
| popData | output | 8 | Byte returned by the last pop |
| statusRead | input | 1 | Host reads the status word; acknowledges error flags |
| statusWord | output | 16 | {overflow, underflow, level[5:0], trigger, 7'b0} |
| thrWrite | input | 1 | Load the trigger threshold |
| thrValue | input | 5 | New threshold value |
| trigIrqEn | input | 1 | Lets the trigger flag drive `irq` |
| irq | output | 1 | Interrupt request |

## Verification
The bench fills the queue to exactly 32 bytes and then pushes once more. A design that overwrote the oldest byte, or that let the level wrap to 0, would return the wrong sequence when drained. It pops an empty queue while reading status in the same cycle, where a design that gave the clear priority would lose the new underflow. It steps the occupancy across the threshold to catch a greater-or-equal compare. It also issues simultaneous push and pop, which a design with a wrong pointer or count update would show as a level change or a reordered byte.

// File: rtl/rxfifo_pkg.sv
package rxfifo_pkg;
  // Strobes from control to storage for one cycle
  typedef struct packed {
    logic wrEn;     // store pushData at the write pointer
    logic rdEn;     // fetch the oldest byte into popData
    logic rdEmpty;  // pop against an empty queue: return zero
  } fifoCmd_t;
endpackage

// File: rtl/rxfifo_store.sv
module rxfifo_store #(
  parameter int DEPTH = 32,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  rxfifo_pkg::fifoCmd_t   cmd,
  input  logic [DATA_W-1:0]      wrData,
  output logic [DATA_W-1:0]      rdData
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (cmd.wrEn) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      rdData <= '0;
    end else begin
      if (cmd.wrEn) wrPtr <= nextPtr(wrPtr);
      if (cmd.rdEn) begin
        rdData <= mem[rdPtr];
        rdPtr  <= nextPtr(rdPtr);
      end else if (cmd.rdEmpty) begin
        rdData <= '0;
      end
    end
  end
endmodule

// File: rtl/rxfifo_ctrl.sv
module rxfifo_ctrl #(
  parameter int DEPTH = 32,
  parameter int THR_W = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pushValid,
  input  logic                 popStrobe,
  input  logic                 statusRead,
  input  logic                 thrWrite,
  input  logic [THR_W-1:0]     thrValue,
  input  logic                 trigIrqEn,
  output rxfifo_pkg::fifoCmd_t cmd,
  output logic [15:0]          statusWord,
  output logic                 irq
);
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [LVL_W-1:0] level;
  logic [THR_W-1:0] thrReg;
  logic ovfFlag, udfFlag, trigFlag;
  logic isEmpty, isFull, ovfEvt;

  assign isEmpty = (level == '0);
  assign isFull  = (level == FULL_LVL);

  always_comb begin
    cmd.rdEn    = popStrobe && !isEmpty;
    cmd.rdEmpty = popStrobe && isEmpty;
    cmd.wrEn    = pushValid && (!isFull || cmd.rdEn);
    ovfEvt      = pushValid && isFull && !cmd.rdEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      level   <= '0;
      thrReg  <= '0;
      ovfFlag <= 1'b0;
      udfFlag <= 1'b0;
    end else begin
      case ({cmd.wrEn, cmd.rdEn})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
      if (thrWrite) thrReg <= thrValue;
      // a new event outranks the acknowledge
      if (ovfEvt)          ovfFlag <= 1'b1;
      else if (statusRead) ovfFlag <= 1'b0;
      if (cmd.rdEmpty)     udfFlag <= 1'b1;
      else if (statusRead) udfFlag <= 1'b0;
    end
  end

  assign trigFlag   = (level > LVL_W'(thrReg));
  assign statusWord = {ovfFlag, udfFlag, 6'(level), trigFlag, 7'b0};
  assign irq        = ovfFlag | udfFlag | (trigFlag & trigIrqEn);
endmodule

// File: rtl/rx_byte_fifo.sv
module rx_byte_fifo #(
  parameter int DEPTH = 32,
  parameter int DATA_W = 8,
  parameter int THR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushData,
  input  logic              popStrobe,
  output logic [DATA_W-1:0] popData,
  input  logic              statusRead,
  output logic [15:0]       statusWord,
  input  logic              thrWrite,
  input  logic [THR_W-1:0]  thrValue,
  input  logic              trigIrqEn,
  output logic              irq
);
  rxfifo_pkg::fifoCmd_t cmd;

  rxfifo_ctrl #(.DEPTH(DEPTH), .THR_W(THR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .popStrobe(popStrobe),
    .statusRead(statusRead), .thrWrite(thrWrite), .thrValue(thrValue),
    .trigIrqEn(trigIrqEn), .cmd(cmd), .statusWord(statusWord), .irq(irq)
  );

  rxfifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrData(pushData), .rdData(popData)
  );
endmodule

// File: rtl/rxfifo_chk.sv
module rxfifo_chk #(
  parameter int DEPTH = 32
) (
  input logic        clk,
  input logic        rstN,
  input logic        pushValid,
  input logic        popStrobe,
  input logic        statusRead,
  input logic        trigIrqEn,
  input logic [15:0] statusWord,
  input logic        irq
);
  logic [5:0] lvl;
  assign lvl = statusWord[13:8];

  AST_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rstN) lvl <= 6'(DEPTH)); // R3
  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rstN) statusWord[6:0] == 7'b0); // R3
  AST_UDF_SET: assert property (@(posedge clk) disable iff (!rstN) (popStrobe && lvl == 6'd0) |=> statusWord[14]); // R4
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rstN) (pushValid && !popStrobe && lvl == 6'(DEPTH)) |=> (statusWord[15] && lvl == 6'(DEPTH))); // R5
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rstN) (statusRead && !(popStrobe && lvl == 6'd0)) |=> !statusWord[14]); // R6
  AST_IRQ_ERR: assert property (@(posedge clk) disable iff (!rstN) (statusWord[15] || statusWord[14]) |-> irq); // R8
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN) irq |-> (statusWord[15] || statusWord[14] || (statusWord[7] && trigIrqEn))); // R8
  AST_SIM_HOLD: assert property (@(posedge clk) disable iff (!rstN) (pushValid && popStrobe && lvl != 6'd0) |=> lvl == $past(lvl)); // R9
endmodule

bind rx_byte_fifo rxfifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .pushValid(pushValid), .popStrobe(popStrobe),
  .statusRead(statusRead), .trigIrqEn(trigIrqEn), .statusWord(statusWord), .irq(irq)
);

// File: tb/rx_byte_fifo_tb.sv
module rx_byte_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushValid = 1'b0, popStrobe = 1'b0, statusRead = 1'b0;
  logic thrWrite = 1'b0, trigIrqEn = 1'b0;
  logic [7:0] pushData = '0;
  logic [4:0] thrValue = '0;
  logic [7:0] popData;
  logic [15:0] statusWord;
  logic irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_byte_fifo u_dut (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushData(pushData),
    .popStrobe(popStrobe), .popData(popData), .statusRead(statusRead),
    .statusWord(statusWord), .thrWrite(thrWrite), .thrValue(thrValue),
    .trigIrqEn(trigIrqEn), .irq(irq)
  );

  // {push, data[7:0], pop, chkData, expLvl[5:0], expData[7:0]}
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b1, 8'hA1, 1'b0, 1'b0, 6'd1, 8'h00},
    {1'b1, 8'hB2, 1'b0, 1'b0, 6'd2, 8'h00},
    {1'b1, 8'hC3, 1'b0, 1'b0, 6'd3, 8'h00},
    {1'b0, 8'h00, 1'b1, 1'b1, 6'd2, 8'hA1},
    {1'b1, 8'hD4, 1'b1, 1'b1, 6'd2, 8'hB2},
    {1'b0, 8'h00, 1'b1, 1'b1, 6'd1, 8'hC3},
    {1'b0, 8'h00, 1'b1, 1'b1, 6'd0, 8'hD4},
    {1'b1, 8'h5E, 1'b0, 1'b0, 6'd1, 8'h00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // drive inputs for one clock, return at the following falling edge
  task automatic cyc(input logic p, input logic [7:0] d, input logic q, input logic s);
    pushValid = p; pushData = d; popStrobe = q; statusRead = s;
    @(negedge clk);
    pushValid = 1'b0; popStrobe = 1'b0; statusRead = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset();
    check("R1 status", statusWord, 16'h0000);
    check("R1 popData", popData, 8'h00);
    check("R1 irq", irq, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      cyc(VEC[i][24], VEC[i][23:16], VEC[i][15], 1'b0);
      check("R3/R9 level", statusWord[13:8], VEC[i][13:8]);
      if (VEC[i][14]) check("R2/R9 order", popData, VEC[i][7:0]);
    end

    // fill to capacity
    doReset();
    for (int i = 0; i < 32; i++) cyc(1'b1, 8'(i + 8'h40), 1'b0, 1'b0);
    check("R3 full level", statusWord[13:8], 6'd32);
    check("R3 low bits", statusWord[6:0], 7'h00);
    cyc(1'b1, 8'hFF, 1'b0, 1'b0);
    check("R5 overflow flag", statusWord[15], 1'b1);
    check("R5 level held", statusWord[13:8], 6'd32);
    check("R8 irq on overflow", irq, 1'b1);
    // status read: flag visible in the read cycle, cleared after
    statusRead = 1'b1;
    #1 check("R6 visible in read cycle", statusWord[15], 1'b1);
    cyc(1'b0, 8'h00, 1'b0, 1'b1);
    check("R6 overflow cleared", statusWord[15], 1'b0);
    // full + push + pop: both accepted
    cyc(1'b1, 8'h60, 1'b1, 1'b0);
    check("R9 full push+pop level", statusWord[13:8], 6'd32);
    check("R9 full push+pop data", popData, 8'h40);
    check("R5 no overflow with pop", statusWord[15], 1'b0);
    for (int i = 1; i < 32; i++) begin
      cyc(1'b0, 8'h00, 1'b1, 1'b0);
      check("R2/R5 drain order", popData, 8'(i + 8'h40));
    end
    cyc(1'b0, 8'h00, 1'b1, 1'b0);
    check("R5 dropped byte absent", popData, 8'h60);
    check("R3 empty level", statusWord[13:8], 6'd0);

    // underflow
    cyc(1'b0, 8'h00, 1'b1, 1'b0);
    check("R4 underflow flag", statusWord[14], 1'b1);
    check("R4 zero data", popData, 8'h00);
    check("R4 level unchanged", statusWord[13:8], 6'd0);
    check("R8 irq on underflow", irq, 1'b1);
    cyc(1'b0, 8'h00, 1'b1, 1'b1);
    check("R6 new event wins", statusWord[14], 1'b1);
    cyc(1'b0, 8'h00, 1'b0, 1'b1);
    check("R6 underflow cleared", statusWord[14], 1'b0);
    check("R8 irq cleared", irq, 1'b0);

    // threshold strictly greater
    thrWrite = 1'b1; thrValue = 5'd3;
    @(negedge clk);
    thrWrite = 1'b0;
    for (int i = 0; i < 3; i++) cyc(1'b1, 8'(i), 1'b0, 1'b0);
    check("R7 level equal threshold", statusWord[7], 1'b0);
    cyc(1'b1, 8'h03, 1'b0, 1'b0);
    check("R7 level above threshold", statusWord[7], 1'b1);
    check("R8 trigger masked", irq, 1'b0);
    trigIrqEn = 1'b1;
    #1 check("R8 trigger enabled", irq, 1'b1);
    cyc(1'b0, 8'h00, 1'b1, 1'b0);
    check("R7 back to threshold", statusWord[7], 1'b0);
    check("R8 irq follows trigger", irq, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule